// File: doc/BRIEF.md
# Deferred Reply Issue Sequencer

This block belongs to an agent on a pipelined split-transaction processor bus that may postpone its answer to a request. It keeps a small table of postponed transactions. Each entry holds the 8-bit transaction identifier that came with the original request and the kind of that request. When the local side reports that an entry has finished, the block issues a deferred reply. The reply starts with a request phase whose type code is all zeros, whose address bits 23:16 carry the saved identifier, and whose defer-enable flag is low. One cycle later the block drives its own snoop-result indications, because nobody else snoops this transaction. These indications pass cache-line ownership back to the original requester. One cycle after that it states whether a data phase follows.

New entries are written through a capture port that gives the slot, the identifier and the kind. Completions arrive as a per-slot bit mask, together with per-slot shared and modified status bits. Several entries may therefore finish in the same cycle. The lowest-numbered finished entry is issued first, at most one reply per cycle, and an entry is freed in the cycle its reply request phase is issued.

Top module: `defer_reply_seq`

## Requirements
- R1: After synchronous reset the table is empty and every output is low (request strobe, address, code, defer-enable, snoop-result valid, hit, hit-modified, data-phase valid and data flag).
- R2: A capture writes identifier and kind into the given slot and marks it pending. A completion bit for a slot that is not pending or is already completed is ignored and produces no reply. Kind codes are: 0 full-line memory read, 1 partial memory read, 2 I/O read, 3 interrupt acknowledge, 4 memory write, 5 I/O write, 6 invalidate, 7 reserved.
- R3: A completion sampled at clock edge k, with no other completed entry ahead of it, makes the request strobe high from edge k+1 for exactly one cycle.
- R4: While the request strobe is high, the request code is 5'b00000, address bits 23:16 equal the saved identifier, address bits 15:0 are zero, and defer-enable is low.
- R5: When several entries are completed at once, replies are issued one per cycle in increasing slot order.
- R6: An entry is freed when its reply is issued. A later completion bit for it without a new capture gives no reply.
- R7: The snoop-result valid follows the request strobe by one cycle. Hit is high only for a full-line memory read completed with the shared status bit set.
- R8: Hit-modified is high only for an invalidate completed with the modified status bit set. Hit and hit-modified are never high together.
- R9: The data-phase valid follows snoop-result valid by one cycle. Its data flag is high for kinds 0 to 3, and for kind 6 with modified status. It is low for kinds 4, 5, 7 and for an unmodified invalidate.
- R10: When a capture and a completion bit target the same slot in the same cycle, the capture wins and the slot is left pending but not completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Write a new postponed entry |
| cap_slot | input | 3 | Slot index for the capture |
| cap_tag | input | 8 | Identifier of the original request |
| cap_kind | input | 3 | Kind of the original request |
| done_vec | input | 8 | Per-slot completion bits |
| done_shared | input | 8 | Per-slot shared status, taken with completion |
| done_modified | input | 8 | Per-slot modified status, taken with completion |
| rq_strobe | output | 1 | Reply request phase present |
| rq_code | output | 5 | Request type code of the reply |
| rq_addr | output | 24 | Request address, identifier in bits 23:16 |
| rq_defer_en | output | 1 | Defer-enable flag of the reply |
| sr_valid | output | 1 | Snoop-result phase of a reply |
| sr_hit | output | 1 | Line to be held shared |
| sr_hitm | output | 1 | Modified line returned |
| dp_valid | output | 1 | Data-phase decision slot of a reply |
| dp_data | output | 1 | A data phase follows |

## Verification
A completion bit sampled at edge k puts the request phase on the outputs after edge k+1. The snoop result follows after edge k+2, and the data decision after edge k+3. A capture takes one edge before its completion counts. The reference model in the bench advances on the same rising edge as the design and moves its expectations through three stage variables that match these delays. All outputs are compared at the falling edge, after both have settled. Contention cases let completions pile up in one mask, so the increasing-slot order can be seen cycle by cycle.

// File: rtl/dr_pkg.sv
package dr_pkg;

    parameter int DR_SLOTS   = 8;
    parameter int DR_TAG_W   = 8;
    parameter int DR_ADDR_W  = 24;
    parameter int DR_TAG_LSB = 16;
    parameter int DR_CODE_W  = 5;
    parameter int DR_KIND_W  = 3;

    localparam logic [DR_CODE_W-1:0] DR_REPLY_CODE = '0;

    typedef enum logic [DR_KIND_W-1:0] {
        K_RD_LINE = 3'd0,
        K_RD_PART = 3'd1,
        K_IO_RD   = 3'd2,
        K_INTA    = 3'd3,
        K_MEM_WR  = 3'd4,
        K_IO_WR   = 3'd5,
        K_INVAL   = 3'd6,
        K_RSVD    = 3'd7
    } orig_kind_e;

    typedef struct packed {
        logic                valid;
        logic                done;
        logic                shared;
        logic                modified;
        orig_kind_e          kind;
        logic [DR_TAG_W-1:0] tag;
    } slot_t;

    typedef struct packed {
        logic                valid;
        logic [DR_TAG_W-1:0] tag;
        logic                hit;
        logic                hitm;
        logic                data;
    } rq_stage_t;

    typedef struct packed {
        logic valid;
        logic hit;
        logic hitm;
        logic data;
    } sr_stage_t;

    typedef struct packed {
        logic valid;
        logic data;
    } dp_stage_t;

    function automatic logic f_hit(orig_kind_e k, logic sh);
        return (k == K_RD_LINE) && sh;
    endfunction

    function automatic logic f_hitm(orig_kind_e k, logic md);
        return (k == K_INVAL) && md;
    endfunction

    function automatic logic f_data(orig_kind_e k, logic md);
        case (k)
            K_RD_LINE, K_RD_PART, K_IO_RD, K_INTA: return 1'b1;
            K_INVAL:                               return md;
            default:                               return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dr_table.sv
module dr_table
    import dr_pkg::*;
#(
    parameter int SLOTS = DR_SLOTS,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_valid,
    input  logic [IDX_W-1:0]      cap_slot,
    input  logic [DR_TAG_W-1:0]   cap_tag,
    input  logic [DR_KIND_W-1:0]  cap_kind,
    input  logic [SLOTS-1:0]      done_vec,
    input  logic [SLOTS-1:0]      done_shared,
    input  logic [SLOTS-1:0]      done_modified,
    input  logic                  free_valid,
    input  logic [IDX_W-1:0]      free_slot,
    output slot_t [SLOTS-1:0]     slots
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic cap_here;
        logic free_here;
        logic done_here;

        assign cap_here  = cap_valid && (cap_slot == IDX_W'(i));
        assign free_here = free_valid && (free_slot == IDX_W'(i));
        assign done_here = done_vec[i] && slots[i].valid && !slots[i].done;

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (cap_here) begin
                slots[i].valid    <= 1'b1;
                slots[i].done     <= 1'b0;
                slots[i].shared   <= 1'b0;
                slots[i].modified <= 1'b0;
                slots[i].kind     <= orig_kind_e'(cap_kind);
                slots[i].tag      <= cap_tag;
            end else if (free_here) begin
                slots[i].valid <= 1'b0;
                slots[i].done  <= 1'b0;
            end else if (done_here) begin
                slots[i].done     <= 1'b1;
                slots[i].shared   <= done_shared[i];
                slots[i].modified <= done_modified[i];
            end
        end
    end

endmodule

// File: rtl/dr_pick.sv
module dr_pick
    import dr_pkg::*;
#(
    parameter int SLOTS = DR_SLOTS,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  slot_t [SLOTS-1:0] slots,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_idx
);

    logic [SLOTS-1:0] ready;

    for (genvar i = 0; i < SLOTS; i++) begin : g_ready
        assign ready[i] = slots[i].valid && slots[i].done;
    end

    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (ready[i]) begin
                grant_valid = 1'b1;
                grant_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dr_phase_pipe.sv
module dr_phase_pipe
    import dr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  g_valid,
    input  orig_kind_e            g_kind,
    input  logic [DR_TAG_W-1:0]   g_tag,
    input  logic                  g_shared,
    input  logic                  g_modified,
    output logic                  rq_strobe,
    output logic [DR_CODE_W-1:0]  rq_code,
    output logic [DR_ADDR_W-1:0]  rq_addr,
    output logic                  rq_defer_en,
    output logic                  sr_valid,
    output logic                  sr_hit,
    output logic                  sr_hitm,
    output logic                  dp_valid,
    output logic                  dp_data
);

    rq_stage_t rq_q;
    sr_stage_t sr_q;
    dp_stage_t dp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_q <= '0;
            sr_q <= '0;
            dp_q <= '0;
        end else begin
            rq_q.valid <= g_valid;
            rq_q.tag   <= g_valid ? g_tag : '0;
            rq_q.hit   <= g_valid && f_hit(g_kind, g_shared);
            rq_q.hitm  <= g_valid && f_hitm(g_kind, g_modified);
            rq_q.data  <= g_valid && f_data(g_kind, g_modified);
            sr_q.valid <= rq_q.valid;
            sr_q.hit   <= rq_q.hit;
            sr_q.hitm  <= rq_q.hitm;
            sr_q.data  <= rq_q.data;
            dp_q.valid <= sr_q.valid;
            dp_q.data  <= sr_q.data;
        end
    end

    assign rq_strobe   = rq_q.valid;
    assign rq_code     = DR_REPLY_CODE;
    assign rq_addr     = DR_ADDR_W'(rq_q.tag) << DR_TAG_LSB;
    assign rq_defer_en = 1'b0;
    assign sr_valid    = sr_q.valid;
    assign sr_hit      = sr_q.hit;
    assign sr_hitm     = sr_q.hitm;
    assign dp_valid    = dp_q.valid;
    assign dp_data     = dp_q.data;

endmodule

// File: rtl/defer_reply_seq.sv
module defer_reply_seq
    import dr_pkg::*;
#(
    parameter int SLOTS = DR_SLOTS,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_valid,
    input  logic [IDX_W-1:0]      cap_slot,
    input  logic [DR_TAG_W-1:0]   cap_tag,
    input  logic [DR_KIND_W-1:0]  cap_kind,
    input  logic [SLOTS-1:0]      done_vec,
    input  logic [SLOTS-1:0]      done_shared,
    input  logic [SLOTS-1:0]      done_modified,
    output logic                  rq_strobe,
    output logic [DR_CODE_W-1:0]  rq_code,
    output logic [DR_ADDR_W-1:0]  rq_addr,
    output logic                  rq_defer_en,
    output logic                  sr_valid,
    output logic                  sr_hit,
    output logic                  sr_hitm,
    output logic                  dp_valid,
    output logic                  dp_data
);

    slot_t [SLOTS-1:0] slots;
    logic              grant_valid;
    logic [IDX_W-1:0]  grant_idx;
    slot_t             granted;

    dr_table #(.SLOTS(SLOTS)) u_table (
        .clk           (clk),
        .rst           (rst),
        .cap_valid     (cap_valid),
        .cap_slot      (cap_slot),
        .cap_tag       (cap_tag),
        .cap_kind      (cap_kind),
        .done_vec      (done_vec),
        .done_shared   (done_shared),
        .done_modified (done_modified),
        .free_valid    (grant_valid),
        .free_slot     (grant_idx),
        .slots         (slots)
    );

    dr_pick #(.SLOTS(SLOTS)) u_pick (
        .slots       (slots),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    assign granted = slots[grant_idx];

    dr_phase_pipe u_pipe (
        .clk         (clk),
        .rst         (rst),
        .g_valid     (grant_valid),
        .g_kind      (granted.kind),
        .g_tag       (granted.tag),
        .g_shared    (granted.shared),
        .g_modified  (granted.modified),
        .rq_strobe   (rq_strobe),
        .rq_code     (rq_code),
        .rq_addr     (rq_addr),
        .rq_defer_en (rq_defer_en),
        .sr_valid    (sr_valid),
        .sr_hit      (sr_hit),
        .sr_hitm     (sr_hitm),
        .dp_valid    (dp_valid),
        .dp_data     (dp_data)
    );

endmodule

// File: rtl/dr_seq_checker.sv
module dr_seq_checker
    import dr_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 rq_strobe,
    input logic [DR_ADDR_W-1:0] rq_addr,
    input logic                 sr_valid,
    input logic                 sr_hit,
    input logic                 sr_hitm,
    input logic                 dp_valid
);

    assert_addr_low_clear_R4: assert property (@(posedge clk) disable iff (rst)
        rq_strobe |-> (rq_addr[DR_TAG_LSB-1:0] == '0));

    assert_idle_addr_R1: assert property (@(posedge clk) disable iff (rst)
        !rq_strobe |-> (rq_addr == '0));

    assert_snoop_after_req_R7: assert property (@(posedge clk) disable iff (rst)
        rq_strobe |=> sr_valid);

    assert_no_stray_snoop_R7: assert property (@(posedge clk) disable iff (rst)
        !rq_strobe |=> !sr_valid);

    assert_hit_pair_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(sr_hit && sr_hitm));

    assert_quiet_snoop_R8: assert property (@(posedge clk) disable iff (rst)
        !sr_valid |-> (!sr_hit && !sr_hitm));

    assert_data_after_snoop_R9: assert property (@(posedge clk) disable iff (rst)
        sr_valid |=> dp_valid);

    assert_no_stray_data_R9: assert property (@(posedge clk) disable iff (rst)
        !sr_valid |=> !dp_valid);

endmodule

bind defer_reply_seq dr_seq_checker i_dr_seq_checker (
    .clk       (clk),
    .rst       (rst),
    .rq_strobe (rq_strobe),
    .rq_addr   (rq_addr),
    .sr_valid  (sr_valid),
    .sr_hit    (sr_hit),
    .sr_hitm   (sr_hitm),
    .dp_valid  (dp_valid)
);

// File: tb/test_defer_reply_seq.sv
`timescale 1ns/1ps
module test_defer_reply_seq;

    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_valid = 1'b0;
    logic [2:0]  cap_slot = '0;
    logic [7:0]  cap_tag = '0;
    logic [2:0]  cap_kind = '0;
    logic [7:0]  done_vec = '0;
    logic [7:0]  done_shared = '0;
    logic [7:0]  done_modified = '0;
    logic        rq_strobe;
    logic [4:0]  rq_code;
    logic [23:0] rq_addr;
    logic        rq_defer_en;
    logic        sr_valid, sr_hit, sr_hitm, dp_valid, dp_data;

    always #4 clk = ~clk;

    defer_reply_seq i_defer_reply_seq (
        .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_slot(cap_slot),
        .cap_tag(cap_tag), .cap_kind(cap_kind), .done_vec(done_vec),
        .done_shared(done_shared), .done_modified(done_modified),
        .rq_strobe(rq_strobe), .rq_code(rq_code), .rq_addr(rq_addr),
        .rq_defer_en(rq_defer_en), .sr_valid(sr_valid), .sr_hit(sr_hit),
        .sr_hitm(sr_hitm), .dp_valid(dp_valid), .dp_data(dp_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model: table and three phase stages
    bit m_valid [NS];
    bit m_done  [NS];
    bit m_sh    [NS];
    bit m_md    [NS];
    int m_kind  [NS];
    int m_tag   [NS];
    bit e_rq, e_rq_hit, e_rq_hitm, e_rq_data;
    int e_rq_tag;
    bit e_sr, e_sr_hit, e_sr_hitm, e_sr_data;
    bit e_dp, e_dp_data;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) begin
                m_valid[i] = 0; m_done[i] = 0; m_sh[i] = 0; m_md[i] = 0;
                m_kind[i] = 0; m_tag[i] = 0;
            end
            e_rq = 0; e_rq_tag = 0; e_rq_hit = 0; e_rq_hitm = 0; e_rq_data = 0;
            e_sr = 0; e_sr_hit = 0; e_sr_hitm = 0; e_sr_data = 0;
            e_dp = 0; e_dp_data = 0;
        end else begin
            int pick;
            bit was_open [NS];
            e_dp = e_sr; e_dp_data = e_sr_data;
            e_sr = e_rq; e_sr_hit = e_rq_hit; e_sr_hitm = e_rq_hitm; e_sr_data = e_rq_data;
            pick = -1;
            for (int i = NS - 1; i >= 0; i--)
                if (m_valid[i] && m_done[i]) pick = i;
            if (pick >= 0) begin
                e_rq      = 1;
                e_rq_tag  = m_tag[pick];
                e_rq_hit  = (m_kind[pick] == 0) && m_sh[pick];
                e_rq_hitm = (m_kind[pick] == 6) && m_md[pick];
                e_rq_data = (m_kind[pick] <= 3) || ((m_kind[pick] == 6) && m_md[pick]);
            end else begin
                e_rq = 0; e_rq_tag = 0; e_rq_hit = 0; e_rq_hitm = 0; e_rq_data = 0;
            end
            for (int i = 0; i < NS; i++) was_open[i] = m_valid[i] && !m_done[i];
            for (int i = 0; i < NS; i++) begin
                if (cap_valid && (int'(cap_slot) == i)) begin
                    m_valid[i] = 1; m_done[i] = 0; m_sh[i] = 0; m_md[i] = 0;
                    m_kind[i] = int'(cap_kind); m_tag[i] = int'(cap_tag);
                end else if (pick == i) begin
                    m_valid[i] = 0; m_done[i] = 0;
                end else if (done_vec[i] && was_open[i]) begin
                    m_done[i] = 1; m_sh[i] = done_shared[i]; m_md[i] = done_modified[i];
                end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            string ra, rb, rc, rd, re, rf;
            ra = rst ? "R1" : "R3 R5 R6";
            rb = rst ? "R1" : "R2 R4 R10";
            rc = rst ? "R1" : "R4";
            rd = rst ? "R1" : "R7";
            re = rst ? "R1" : "R8";
            rf = rst ? "R1" : "R9";
            chk(ra, "rq_strobe", int'(rq_strobe), int'(e_rq));
            chk(rb, "rq_addr", int'(rq_addr), e_rq ? (e_rq_tag << 16) : 0);
            chk(rc, "rq_code", int'(rq_code), 0);
            chk(rc, "rq_defer_en", int'(rq_defer_en), 0);
            chk(rd, "sr_valid", int'(sr_valid), int'(e_sr));
            chk(rd, "sr_hit", int'(sr_hit), int'(e_sr_hit));
            chk(re, "sr_hitm", int'(sr_hitm), int'(e_sr_hitm));
            chk(rf, "dp_valid", int'(dp_valid), int'(e_dp));
            chk(rf, "dp_data", int'(dp_data), int'(e_dp_data));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap_valid = 0; done_vec = '0; done_shared = '0; done_modified = '0;
        end
    endtask

    task automatic cap(int slot, int tag, int kind);
        @(negedge clk);
        cap_valid = 1; cap_slot = 3'(slot); cap_tag = 8'(tag); cap_kind = 3'(kind);
        done_vec = '0;
    endtask

    task automatic fin(logic [7:0] v, logic [7:0] sh, logic [7:0] md);
        @(negedge clk);
        cap_valid = 0; done_vec = v; done_shared = sh; done_modified = md;
    endtask

    initial begin
        idle(3);
        rst = 0;
        idle(2);
        // R5: seven kinds pending, all completed in one mask, issued in slot order
        for (int i = 0; i < 7; i++) cap(i, 8'hA0 + i, i);
        fin(8'h7F, 8'h01, 8'h40);
        idle(10);
        // R7: full-line read without shared status gives no hit
        cap(0, 8'h11, 0);
        fin(8'h01, 8'h00, 8'h00);
        // R8 R9: invalidate without modified status gives neither hitm nor data
        cap(6, 8'h66, 6);
        fin(8'h40, 8'h00, 8'h00);
        idle(5);
        // R6: completion for a freed slot; R2: completion for an empty slot
        fin(8'h81, 8'hFF, 8'hFF);
        idle(5);
        // R10: capture and completion on the same slot in one cycle
        @(negedge clk);
        cap_valid = 1; cap_slot = 3'd3; cap_tag = 8'h33; cap_kind = 3'd4;
        done_vec = 8'h08; done_shared = '0; done_modified = '0;
        idle(5);
        fin(8'h08, 8'h00, 8'h00);
        idle(5);
        // reserved and write kinds, plus contention from the top slot down
        cap(7, 8'h77, 7);
        cap(5, 8'h55, 5);
        cap(4, 8'h44, 4);
        fin(8'hB0, 8'h00, 8'h00);
        idle(8);
        // mixed traffic
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            cap_valid     = ($urandom % 3) == 0;
            cap_slot      = 3'($urandom);
            cap_tag       = 8'($urandom);
            cap_kind      = 3'($urandom);
            done_vec      = 8'($urandom & $urandom);
            done_shared   = 8'($urandom);
            done_modified = 8'($urandom);
        end
        idle(10);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule